// File: doc/BRIEF.md
# Vectored Interrupt Router

This block gathers a wide bank of edge-triggered interrupt vectors and latches each one into a pending bit. Software masks each vector through enable words. Each vector is steered to one of four local cores by a routing byte. A separate byte per 32-vector group then picks which of the eight per-core interrupt lines that group drives. A single global enable bit gates every output, so nothing reaches a core until software has finished programming the tables.

Software reaches all state through a simple 32-bit register port with byte lanes. Writes take effect at the clock edge that samples the request. Read data appears on the cycle after the request. Software reads pending words to find the active vectors. It writes a value back to a pending word to acknowledge the vectors whose bits are set in it. The node field of each routing byte and a per-vector bounce bit are kept only for software; they do not change where an interrupt goes. Addresses below are word addresses.

Top module: `irqc_router`

## Requirements
- R1: After reset every register reads zero and `irq_o` is zero. This covers the control word, the enable words, the routing words, the line-map words and the pending words.
- R2: A rising edge on `vec_i[n]` sets pending bit n. Pending is read at word 0x30 + n/32, bit n%32. The pair 2i (low half) and 2i+1 (high half) forms the 64-bit word i, so vector n sits in 64-bit word n/64 at bit n%64. A level that stays high does not set the bit again once it has been cleared.
- R3: A write to a pending word clears exactly the bits that are 1 in the written data within the byte lanes whose `bus_be_i` bit is set. All other pending bits are left unchanged.
- R4: If a rising edge on a vector and a clear of that same vector fall on one clock edge, the bit stays pending.
- R5: Enable bit n lives in word 0x10 + (n>>5) at bit n&31, and 1 means enabled. A vector that is pending but disabled keeps its pending bit and drives no output. It drives its line again once it is re-enabled.
- R6: Vector n has a routing byte in byte n%4 of word 0x80 + n/4. Bits [3:0] of that byte are a one-hot core map and bits [7:4] a stored node number. A byte-lane write changes only the enabled bytes.
- R7: Group g (vectors 32g..32g+31) has a line-map byte in byte g%4 of word 0x40 + g/4. Bit l of that byte selects line l.
- R8: Output `irq_o[c*8+l]` is high one clock edge after these all hold together: the global enable (bit 0 of word 0x00) is 1, and some vector is pending, enabled, has core bit c set in its routing byte, and belongs to a group whose line-map byte has bit l set.
- R9: The bounce words at 0x20 + k store one bit per vector and read back what was written, per byte lane.
- R10: Read data is registered and appears on the cycle after a read request, and it holds until the next read. A read of an unmapped address returns zero, and a write to one changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| vec_i | input | NUM_VEC | Interrupt vector inputs, rising-edge sensitive |
| bus_req_i | input | 1 | Register access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_be_i | input | 4 | Byte lane enables for writes |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read request |
| irq_o | output | 32 | Per-core interrupt lines, index core*8 + line |

## Verification
Two paths can hit the same pending bit on one clock edge: a fresh rising edge on a vector and the software acknowledge that clears it. The bench provokes this by driving a vector low for a cycle. On a single falling clock edge it then raises that vector and presents a clearing write to its pending word. It judges the outcome by reading the pending word back and requiring the bit to still be set. A second overlap is also checked: disabling or re-enabling a vector while it is pending must move the output line without touching the pending bit. This is judged both at `irq_o` and by readback.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned CORES       = 4;
  localparam int unsigned LINES       = 8;
  localparam int unsigned VEC_PER_GRP = 32;

  // region codes in bus_addr[7:4]
  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [3:0] R_EN   = 4'h1;
  localparam logic [3:0] R_BNC  = 4'h2;
  localparam logic [3:0] R_PND  = 4'h3;
  localparam logic [3:0] R_LMAP = 4'h4;
  // routing region: bus_addr[7:6] == 2'b10

  function automatic logic [31:0] be_mask(input logic [3:0] be);
    logic [31:0] m;
    for (int b = 0; b < 4; b++) m[b*8 +: 8] = {8{be[b]}};
    return m;
  endfunction

  function automatic logic [31:0] be_merge(input logic [31:0] old_w,
                                           input logic [31:0] new_w,
                                           input logic [3:0]  be);
    logic [31:0] m;
    m = be_mask(be);
    return (old_w & ~m) | (new_w & m);
  endfunction
endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/irqc_pending.sv
module irqc_pending #(
  parameter int unsigned NUM_VEC = 256
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_VEC-1:0] vec_i,
  input  logic [NUM_VEC-1:0] clr_i,
  output logic [NUM_VEC-1:0] pend_o
);
  logic [NUM_VEC-1:0] prev_q, pend_q, pend_d, rise;

  always_comb begin
    rise   = vec_i & ~prev_q;
    // a new edge outranks an acknowledge on the same edge
    pend_d = (pend_q & ~clr_i) | rise;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= vec_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs import irqc_pkg::*; #(
  parameter int unsigned NUM_VEC = 256
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     bus_req_i,
  input  logic                     bus_we_i,
  input  logic [7:0]               bus_addr_i,
  input  logic [31:0]              bus_wdata_i,
  input  logic [3:0]               bus_be_i,
  input  logic [NUM_VEC-1:0]       pend_i,
  output logic                     gen_en_o,
  output logic [NUM_VEC-1:0]       en_o,
  output logic [NUM_VEC*CORES-1:0] core_map_o,
  output logic [NUM_VEC/4-1:0]     lmap_o,
  output logic [NUM_VEC-1:0]       clr_o,
  output logic [31:0]              bus_rdata_o
);
  localparam int unsigned VW  = NUM_VEC / VEC_PER_GRP;  // words of 1 bit per vector
  localparam int unsigned LMW = NUM_VEC / 128;          // line-map words
  localparam int unsigned RTW = NUM_VEC / 4;            // routing words

  logic [VW-1:0][31:0]  en_q, en_d, bnc_q, bnc_d;
  logic [LMW-1:0][31:0] lm_q, lm_d;
  logic [RTW-1:0][31:0] rt_q, rt_d;
  logic                 ctl_q, ctl_d;
  logic [31:0]          rd_q, rd_d;
  logic                 wr, rd, hit_rt;
  logic [3:0]           region, sub;
  logic [5:0]           rt_idx;
  logic [31:0]          wmask;

  always_comb begin
    wr     = bus_req_i & bus_we_i;
    rd     = bus_req_i & ~bus_we_i;
    region = bus_addr_i[7:4];
    sub    = bus_addr_i[3:0];
    hit_rt = (bus_addr_i[7:6] == 2'b10);
    rt_idx = bus_addr_i[5:0];
    wmask  = be_mask(bus_be_i);
  end

  // next-state for configuration and acknowledge
  always_comb begin
    ctl_d = ctl_q;
    en_d  = en_q;
    bnc_d = bnc_q;
    lm_d  = lm_q;
    rt_d  = rt_q;
    clr_o = '0;
    if (wr && bus_addr_i == A_CTRL && bus_be_i[0]) ctl_d = bus_wdata_i[0];
    for (int k = 0; k < VW; k++) begin
      if (wr && region == R_EN  && sub == 4'(k)) en_d[k]  = be_merge(en_q[k],  bus_wdata_i, bus_be_i);
      if (wr && region == R_BNC && sub == 4'(k)) bnc_d[k] = be_merge(bnc_q[k], bus_wdata_i, bus_be_i);
      if (wr && region == R_PND && sub == 4'(k)) clr_o[k*32 +: 32] = bus_wdata_i & wmask;
    end
    for (int k = 0; k < LMW; k++) begin
      if (wr && region == R_LMAP && sub == 4'(k)) lm_d[k] = be_merge(lm_q[k], bus_wdata_i, bus_be_i);
    end
    for (int k = 0; k < RTW; k++) begin
      if (wr && hit_rt && rt_idx == 6'(k)) rt_d[k] = be_merge(rt_q[k], bus_wdata_i, bus_be_i);
    end
  end

  // read multiplexer
  always_comb begin
    rd_d = '0;
    if (bus_addr_i == A_CTRL) rd_d = {31'b0, ctl_q};
    for (int k = 0; k < VW; k++) begin
      if (region == R_EN  && sub == 4'(k)) rd_d = en_q[k];
      if (region == R_BNC && sub == 4'(k)) rd_d = bnc_q[k];
      if (region == R_PND && sub == 4'(k)) rd_d = pend_i[k*32 +: 32];
    end
    for (int k = 0; k < LMW; k++) begin
      if (region == R_LMAP && sub == 4'(k)) rd_d = lm_q[k];
    end
    for (int k = 0; k < RTW; k++) begin
      if (hit_rt && rt_idx == 6'(k)) rd_d = rt_q[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= 1'b0;
      en_q  <= '0;
      bnc_q <= '0;
      lm_q  <= '0;
      rt_q  <= '0;
      rd_q  <= '0;
    end else begin
      if (wr) begin
        ctl_q <= ctl_d;
        en_q  <= en_d;
        bnc_q <= bnc_d;
        lm_q  <= lm_d;
        rt_q  <= rt_d;
      end
      if (rd) rd_q <= rd_d;
    end
  end

  assign gen_en_o    = ctl_q;
  assign en_o        = en_q;
  assign lmap_o      = lm_q;
  assign bus_rdata_o = rd_q;

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_cmap
    assign core_map_o[v*CORES +: CORES] = rt_q[v/4][(v%4)*8 +: CORES];
  end
endmodule

// File: rtl/irqc_fanout.sv
module irqc_fanout import irqc_pkg::*; #(
  parameter int unsigned NUM_VEC = 256
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  gen_en_i,
  input  logic [NUM_VEC-1:0]                    pend_i,
  input  logic [NUM_VEC-1:0]                    en_i,
  input  logic [NUM_VEC*CORES-1:0]              core_map_i,
  input  logic [(NUM_VEC/VEC_PER_GRP)*LINES-1:0] lmap_i,
  output logic [CORES*LINES-1:0]                irq_o
);
  localparam int unsigned GRP = NUM_VEC / VEC_PER_GRP;

  logic [CORES-1:0][GRP-1:0] grp_hit;
  logic [CORES*LINES-1:0]    irq_d, irq_q;

  for (genvar c = 0; c < CORES; c++) begin : g_core
    for (genvar g = 0; g < GRP; g++) begin : g_grp
      logic [VEC_PER_GRP-1:0] sel;
      for (genvar j = 0; j < VEC_PER_GRP; j++) begin : g_vec
        assign sel[j] = pend_i[g*VEC_PER_GRP+j] & en_i[g*VEC_PER_GRP+j]
                      & core_map_i[(g*VEC_PER_GRP+j)*CORES + c];
      end
      assign grp_hit[c][g] = |sel;
    end
  end

  always_comb begin
    irq_d = '0;
    for (int c = 0; c < CORES; c++) begin
      for (int l = 0; l < LINES; l++) begin
        for (int g = 0; g < GRP; g++) begin
          irq_d[c*LINES+l] = irq_d[c*LINES+l] | (grp_hit[c][g] & lmap_i[g*LINES+l]);
        end
      end
    end
    irq_d = irq_d & {(CORES*LINES){gen_en_i}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= '0;
    else         irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irqc_router.sv
module irqc_router import irqc_pkg::*; #(
  parameter int unsigned NUM_VEC = 256
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_VEC-1:0]       vec_i,
  input  logic                     bus_req_i,
  input  logic                     bus_we_i,
  input  logic [7:0]               bus_addr_i,
  input  logic [31:0]              bus_wdata_i,
  input  logic [3:0]               bus_be_i,
  output logic [31:0]              bus_rdata_o,
  output logic [CORES*LINES-1:0]   irq_o
);
  logic                     rst_sync_n;
  logic                     gen_en;
  logic [NUM_VEC-1:0]       pend, en_vec, clr;
  logic [NUM_VEC*CORES-1:0] core_map;
  logic [NUM_VEC/4-1:0]     lmap;

  irqc_rst_sync u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_sync_n)
  );

  irqc_pending #(.NUM_VEC(NUM_VEC)) u_pend (
    .clk_i (clk_i),
    .rst_ni(rst_sync_n),
    .vec_i (vec_i),
    .clr_i (clr),
    .pend_o(pend)
  );

  irqc_regs #(.NUM_VEC(NUM_VEC)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .bus_req_i  (bus_req_i),
    .bus_we_i   (bus_we_i),
    .bus_addr_i (bus_addr_i),
    .bus_wdata_i(bus_wdata_i),
    .bus_be_i   (bus_be_i),
    .pend_i     (pend),
    .gen_en_o   (gen_en),
    .en_o       (en_vec),
    .core_map_o (core_map),
    .lmap_o     (lmap),
    .clr_o      (clr),
    .bus_rdata_o(bus_rdata_o)
  );

  irqc_fanout #(.NUM_VEC(NUM_VEC)) u_fan (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .gen_en_i  (gen_en),
    .pend_i    (pend),
    .en_i      (en_vec),
    .core_map_i(core_map),
    .lmap_i    (lmap),
    .irq_o     (irq_o)
  );
endmodule

// File: rtl/irqc_router_chk.sv
module irqc_router_chk #(
  parameter int unsigned NUM_VEC = 256
) (
  input logic               clk_i,
  input logic               rst_n,
  input logic [NUM_VEC-1:0] vec_i,
  input logic [NUM_VEC-1:0] pend,
  input logic [NUM_VEC-1:0] clr,
  input logic [NUM_VEC-1:0] en_vec,
  input logic               gen_en,
  input logic               bus_req_i,
  input logic               bus_we_i,
  input logic [31:0]        bus_rdata_o,
  input logic [31:0]        irq_o
);
  // R8: no line without the global enable one edge earlier
  a_r8_needs_global: assert property (@(posedge clk_i) disable iff (!rst_n)
    (irq_o != '0) |-> $past(gen_en));

  // R8 / R5: no line without a pending, enabled vector one edge earlier
  a_r5_needs_live: assert property (@(posedge clk_i) disable iff (!rst_n)
    (irq_o != '0) |-> ($past(pend & en_vec) != '0));

  // R3: pending bits only drop when acknowledged
  a_r3_no_silent_drop: assert property (@(posedge clk_i) disable iff (!rst_n)
    (($past(pend) & ~$past(clr) & ~pend) == '0));

  // R2 / R4: a rising edge always leaves the bit pending, even against a clear
  a_r4_edge_sets: assert property (@(posedge clk_i) disable iff (!rst_n)
    (($past(vec_i) & ~$past(vec_i, 2) & ~pend) == '0));

  // R10: read data holds between reads
  a_r10_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_n)
    !$past(bus_req_i & ~bus_we_i) |-> $stable(bus_rdata_o));
endmodule

bind irqc_router irqc_router_chk #(.NUM_VEC(NUM_VEC)) u_chk (
  .clk_i      (clk_i),
  .rst_n      (rst_sync_n),
  .vec_i      (vec_i),
  .pend       (pend),
  .clr        (clr),
  .en_vec     (en_vec),
  .gen_en     (gen_en),
  .bus_req_i  (bus_req_i),
  .bus_we_i   (bus_we_i),
  .bus_rdata_o(bus_rdata_o),
  .irq_o      (irq_o)
);

// File: tb/irqc_router_tb.sv
module irqc_router_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [255:0] vec;
  logic         req, we;
  logic [7:0]   addr;
  logic [31:0]  wdata;
  logic [3:0]   be;
  logic [31:0]  rdata;
  logic [31:0]  irq;

  int unsigned  checks = 0;
  int unsigned  errors = 0;
  logic [31:0]  exp_q[$];
  string        tag_q[$];
  logic         rd_seen;

  always #2 clk = ~clk;

  irqc_router #(.NUM_VEC(256)) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .vec_i      (vec),
    .bus_req_i  (req),
    .bus_we_i   (we),
    .bus_addr_i (addr),
    .bus_wdata_i(wdata),
    .bus_be_i   (be),
    .bus_rdata_o(rdata),
    .irq_o      (irq)
  );

  // monitor: note read requests at the edge, compare half a cycle later
  always @(posedge clk) rd_seen <= req & ~we;

  always @(negedge clk) begin
    if (rd_seen === 1'b1) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R10 unexpected read data actual=%h expected=none", rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          errors++;
          $display("FAIL %s read actual=%h expected=%h", t, rdata, e);
        end
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] b);
    req = 1'b1; we = 1'b1; addr = a; wdata = d; be = b;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic chk_irq(input logic [31:0] e, input string t);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s irq actual=%h expected=%h", t, irq, e);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; vec = '0; req = 1'b0; we = 1'b0;
    addr = '0; wdata = '0; be = '0;
    step(3);
    rst_n = 1'b1;
    step(3);

    // R1: reset state
    chk_irq(32'h0, "R1");
    rd(8'h00, 32'h0, "R1");
    rd(8'h10, 32'h0, "R1");
    rd(8'h81, 32'h0, "R1");
    rd(8'h40, 32'h0, "R1");
    rd(8'h30, 32'h0, "R1");

    // R6: routing bytes, vector 5 -> core 2 node 3, vector 4 -> core 0 node 1
    wr(8'h81, 32'h0000_3400, 4'b0010);
    rd(8'h81, 32'h0000_3400, "R6");
    wr(8'h81, 32'hFFFF_FF11, 4'b0001);
    rd(8'h81, 32'h0000_3411, "R6");

    // R7: group 0 -> line 3
    wr(8'h40, 32'h0000_0008, 4'b0001);
    rd(8'h40, 32'h0000_0008, "R7");

    // R5: enable vector 5
    wr(8'h10, 32'h0000_0020, 4'hF);

    // R2 / R8: edge while global enable is off
    vec[5] = 1'b1;
    step(2);
    chk_irq(32'h0, "R8");
    rd(8'h30, 32'h0000_0020, "R2");

    // R8: global enable on
    wr(8'h00, 32'h1, 4'b0001);
    step(1);
    chk_irq(32'h0008_0000, "R8");

    // R5: disable keeps pending, re-enable drives again
    wr(8'h10, 32'h0, 4'hF);
    step(1);
    chk_irq(32'h0, "R5");
    rd(8'h30, 32'h0000_0020, "R5");
    wr(8'h10, 32'h0000_0020, 4'hF);
    step(1);
    chk_irq(32'h0008_0000, "R5");

    // R3: acknowledge; held level does not re-pend (R2)
    wr(8'h30, 32'h0000_0020, 4'hF);
    step(1);
    chk_irq(32'h0, "R3");
    rd(8'h30, 32'h0, "R2");

    // R3: selective clear and byte lanes
    vec[5] = 1'b0;
    step(1);
    vec[4] = 1'b1; vec[5] = 1'b1;
    step(2);
    rd(8'h30, 32'h0000_0030, "R2");
    wr(8'h30, 32'h0000_0020, 4'b0001);
    rd(8'h30, 32'h0000_0010, "R3");
    wr(8'h30, 32'hFFFF_FFFF, 4'b1110);
    rd(8'h30, 32'h0000_0010, "R3");

    // R4: edge and clear on the same clock edge
    vec[4] = 1'b0;
    step(1);
    vec[4] = 1'b1;
    wr(8'h30, 32'h0000_0010, 4'hF);
    rd(8'h30, 32'h0000_0010, "R4");

    // R8: vector 200 -> core 3, group 6 -> line 7
    wr(8'hB2, 32'h0000_0008, 4'b0001);
    wr(8'h41, 32'h0080_0000, 4'b0100);
    wr(8'h16, 32'h0000_0100, 4'hF);
    vec[200] = 1'b1;
    step(2);
    chk_irq(32'h8000_0000, "R8");
    rd(8'h36, 32'h0000_0100, "R2");

    // R7: remap group 6 to line 0
    wr(8'h41, 32'h0001_0000, 4'b0100);
    step(1);
    chk_irq(32'h0100_0000, "R7");

    // R8: global enable off silences everything
    wr(8'h00, 32'h0, 4'b0001);
    step(1);
    chk_irq(32'h0, "R8");

    // R9: bounce words
    wr(8'h22, 32'hA5A5_A5A5, 4'b1100);
    rd(8'h22, 32'hA5A5_0000, "R9");

    // R10: unmapped space
    wr(8'h7F, 32'hFFFF_FFFF, 4'hF);
    rd(8'h7F, 32'h0, "R10");
    rd(8'h18, 32'h0, "R10");
    step(3);
    rd(8'h81, 32'h0000_3411, "R10");

    step(3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule